// File: doc/BRIEF.md
# SMRAM Window Decoder with High Aliases

This block classifies each host memory access against the system-management RAM region. It looks at a 32-bit physical address, whether the processor is in system-management mode, whether the cycle is an instruction fetch or a data access, and an eight-bit SMRAM control value. From these it decides whether the access lands in the SMRAM region. If it does, the block also decides whether the access is served by DRAM or passed to the PCI bus.

The region is 128KB at 0x000A0000 through 0x000BFFFF, which overlaps the legacy video range. Two more 128KB windows sit at high addresses and alias the same storage. Any hit in any of the three windows yields a DRAM address of 0x000A0000 plus the offset into the window. All outputs are purely combinational. The control value is held elsewhere, and its power-up value is 0x80.

Top module: `smram_window_decoder`

## Requirements
- R1: The base window covers 0x000A0000 to 0x000BFFFF inclusive. When the region is enabled, addresses 0x0009FFFF and 0x000C0000 give hit=0.
- R2: When the region is enabled, addresses 0x0E0A0000 to 0x0E0BFFFF hit, and xlat_addr equals 0x000A0000 plus (addr - 0x0E0A0000).
- R3: When the region is enabled, addresses 0x4E0A0000 to 0x4E0BFFFF hit with the same translation to 0x000A0000 plus offset. 0x4E09FFFF and 0xCE0A0000 do not hit.
- R4: With smm_active=1 the region is enabled whatever the control value is.
- R5: With smm_active=0 the region is enabled only when control bit 0 is 1.
- R6: With the region enabled and control bit 5 set, a data cycle (is_code=0) that hits goes to PCI (to_pci=1, to_dram=0). An instruction fetch (is_code=1) that hits goes to DRAM. With bit 5 clear, every hit goes to DRAM.
- R7: With smm_active=0 and control bit 0 clear, bit 5 has no effect: nothing hits and both route outputs stay 0.
- R8: With the power-up control value 0x80 and smm_active=0, base-window and alias addresses give hit=0 and xlat_addr equal to addr.
- R9: When hit=0, to_dram=0, to_pci=0 and xlat_addr equals addr.
- R10: When hit=1, exactly one of to_dram and to_pci is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 32 | Physical address of the access |
| smm_active | input | 1 | Processor is in system-management mode |
| is_code | input | 1 | 1 = instruction fetch, 0 = data cycle |
| smram_ctl | input | 8 | Control value: bit 0 opens the region outside SMM, bit 5 selects the code/data split |
| hit | output | 1 | Access falls in an enabled SMRAM window |
| to_dram | output | 1 | Hit is served by DRAM |
| to_pci | output | 1 | Hit is forwarded to PCI |
| xlat_addr | output | 32 | DRAM address on a hit, otherwise addr unchanged |

## Verification
The bench probes the bytes on either side of every window edge: 0x0009FFFF, 0x000BFFFF, 0x000C0000, 0x4E09FFFF and 0x0E0BFFFF. A decoder with a wrong size mask or a wrong compare width would let one of these through or reject it. It also uses an alias address with the top bit flipped, which catches a compare that checks too few upper bits. The split mode is driven with both cycle types, inside and outside SMM, and with bit 0 clear and set. A design that lets bit 5 act on its own outside SMM, or that swaps code and data, would show the wrong route. Finally, alias hits are checked for their translated address and misses for an unchanged address, so a missing or leaking translation is seen at the port.

// File: rtl/smram_dec_pkg.sv
package smram_dec_pkg;
   localparam int SMRAM_ADDR_W    = 32;
   localparam int SMRAM_SIZE_LOG2 = 17;
   localparam logic [SMRAM_ADDR_W-1:0] SMRAM_LOCAL_BASE = 32'h000A_0000;
   localparam int CTL_OPEN_BIT  = 0;
   localparam int CTL_SPLIT_BIT = 5;

   typedef struct packed {
      logic hit;
      logic to_dram;
      logic to_pci;
   } smram_route_t;
endpackage

// File: rtl/smram_window_match.sv
module smram_window_match #(
   parameter int ADDR_W    = 32,
   parameter int SIZE_LOG2 = 17,
   parameter logic [ADDR_W-1:0] BASE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              match
);
   localparam int TAG_W = ADDR_W - SIZE_LOG2;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SIZE_LOG2];

   if (SIZE_LOG2 < 1 || SIZE_LOG2 >= ADDR_W) begin : g_bad_size
      $error("window size out of range");
   end
   if (BASE[SIZE_LOG2-1:0] != '0) begin : g_bad_align
      $error("window base not aligned to its size");
   end

   assign match = (addr[ADDR_W-1:SIZE_LOG2] == BASE_TAG);
endmodule

// File: rtl/smram_route_policy.sv
module smram_route_policy
   import smram_dec_pkg::*;
#(
   parameter int OPEN_BIT  = CTL_OPEN_BIT,
   parameter int SPLIT_BIT = CTL_SPLIT_BIT
) (
   input  logic         in_window,
   input  logic         smm_active,
   input  logic         is_code,
   input  logic [7:0]   smram_ctl,
   output smram_route_t route
);
   if (OPEN_BIT > 7 || SPLIT_BIT > 7 || OPEN_BIT == SPLIT_BIT) begin : g_bad_bits
      $error("control bit positions invalid");
   end

   logic enabled;
   logic split;

   assign enabled = smm_active | smram_ctl[OPEN_BIT];
   assign split   = smram_ctl[SPLIT_BIT];

   always_comb begin
      route.hit     = in_window & enabled;
      route.to_pci  = route.hit & split & ~is_code;
      route.to_dram = route.hit & ~route.to_pci;
   end

   always_comb begin
      assert_closed_no_hit_R7: assert (smm_active || smram_ctl[OPEN_BIT] || !route.hit);
      assert_code_never_pci_R6: assert (!(route.to_pci && is_code));
      assert_one_route_R10: assert (!route.hit || $onehot({route.to_dram, route.to_pci}));
   end
endmodule

// File: rtl/smram_window_decoder.sv
module smram_window_decoder
   import smram_dec_pkg::*;
#(
   parameter int ADDR_W      = SMRAM_ADDR_W,
   parameter int SIZE_LOG2   = SMRAM_SIZE_LOG2,
   parameter logic [ADDR_W-1:0] LOCAL_BASE = SMRAM_LOCAL_BASE,
   parameter int NUM_ALIASES = 2,
   parameter logic [NUM_ALIASES-1:0][ADDR_W-1:0] ALIAS_BASES =
      {32'h4E0A_0000, 32'h0E0A_0000}
) (
   input  logic [31:0] addr,
   input  logic        smm_active,
   input  logic        is_code,
   input  logic [7:0]  smram_ctl,
   output logic        hit,
   output logic        to_dram,
   output logic        to_pci,
   output logic [31:0] xlat_addr
);
   localparam int NWIN = NUM_ALIASES + 1;

   if (ADDR_W != 32) begin : g_bad_width
      $error("port width fixed at 32 bits");
   end
   if (NUM_ALIASES < 0) begin : g_bad_alias
      $error("alias count negative");
   end

   logic [NWIN-1:0] win_hit;
   logic            in_window;
   smram_route_t    route;

   smram_window_match #(
      .ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2), .BASE(LOCAL_BASE)
   ) u_match_local (
      .addr(addr), .match(win_hit[0])
   );

   for (genvar i = 0; i < NUM_ALIASES; i++) begin : g_alias
      smram_window_match #(
         .ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2), .BASE(ALIAS_BASES[i])
      ) u_match_alias (
         .addr(addr), .match(win_hit[i+1])
      );
   end

   assign in_window = |win_hit;

   smram_route_policy u_policy (
      .in_window(in_window),
      .smm_active(smm_active),
      .is_code(is_code),
      .smram_ctl(smram_ctl),
      .route(route)
   );

   assign hit     = route.hit;
   assign to_dram = route.to_dram;
   assign to_pci  = route.to_pci;

   always_comb begin
      if (route.hit)
         xlat_addr = {LOCAL_BASE[ADDR_W-1:SIZE_LOG2], addr[SIZE_LOG2-1:0]};
      else
         xlat_addr = addr;
   end

   always_comb begin
      assert_windows_disjoint_R1: assert ($onehot0(win_hit));
      assert_hit_maps_local_R2: assert (!hit ||
         (xlat_addr[ADDR_W-1:SIZE_LOG2] == LOCAL_BASE[ADDR_W-1:SIZE_LOG2] &&
          xlat_addr[SIZE_LOG2-1:0] == addr[SIZE_LOG2-1:0]));
      assert_miss_passthrough_R9: assert (hit || (xlat_addr == addr && !to_dram && !to_pci));
   end
endmodule

// File: tb/smram_window_decoder_tb.sv
module smram_window_decoder_tb;
   localparam time CLK_PERIOD = 10ns;

   typedef struct {
      logic        hit;
      logic        dram;
      logic        pci;
      logic [31:0] xa;
      string       tag;
   } exp_t;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] addr = '0;
   logic        smm_active = 0;
   logic        is_code = 0;
   logic [7:0]  smram_ctl = 8'h80;
   logic        hit, to_dram, to_pci;
   logic [31:0] xlat_addr;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   smram_window_decoder u_dut (
      .addr(addr), .smm_active(smm_active), .is_code(is_code),
      .smram_ctl(smram_ctl), .hit(hit), .to_dram(to_dram),
      .to_pci(to_pci), .xlat_addr(xlat_addr)
   );

   task automatic send(input logic [31:0] a, input logic smm, input logic code,
                       input logic [7:0] ctl, input logic eh, input logic ed,
                       input logic ep, input logic [31:0] ex, input string tag);
      exp_t e;
      @(negedge clk);
      addr = a; smm_active = smm; is_code = code; smram_ctl = ctl;
      e.hit = eh; e.dram = ed; e.pci = ep; e.xa = ex; e.tag = tag;
      sb.push_back(e);
   endtask

   always @(posedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (hit !== e.hit || to_dram !== e.dram || to_pci !== e.pci || xlat_addr !== e.xa) begin
            failures++;
            $display("FAIL %s addr=%h: got hit=%b dram=%b pci=%b xa=%h exp hit=%b dram=%b pci=%b xa=%h",
                     e.tag, addr, hit, to_dram, to_pci, xlat_addr, e.hit, e.dram, e.pci, e.xa);
         end
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1;
      send(32'h000A0000, 0, 0, 8'h80, 0, 0, 0, 32'h000A0000, "R8 reset base");
      send(32'h0E0A1234, 0, 1, 8'h80, 0, 0, 0, 32'h0E0A1234, "R8 reset alias");
      send(32'h000A5678, 1, 0, 8'h00, 1, 1, 0, 32'h000A5678, "R4 smm forced");
      send(32'h000BFFFF, 1, 0, 8'h00, 1, 1, 0, 32'h000BFFFF, "R1 top edge");
      send(32'h0009FFFF, 1, 0, 8'h01, 0, 0, 0, 32'h0009FFFF, "R1 below");
      send(32'h000C0000, 1, 0, 8'h01, 0, 0, 0, 32'h000C0000, "R1 above");
      send(32'h0E0A1234, 1, 0, 8'h00, 1, 1, 0, 32'h000A1234, "R2 alias lo");
      send(32'h0E0BFFFF, 0, 0, 8'h01, 1, 1, 0, 32'h000BFFFF, "R2 alias top");
      send(32'h4E0B0010, 1, 1, 8'h00, 1, 1, 0, 32'h000B0010, "R3 alias hi");
      send(32'h4E09FFFF, 1, 0, 8'h01, 0, 0, 0, 32'h4E09FFFF, "R3 below alias");
      send(32'hCE0A0000, 1, 0, 8'h01, 0, 0, 0, 32'hCE0A0000, "R3 R9 top bit");
      send(32'h000ABCDE, 0, 0, 8'h01, 1, 1, 0, 32'h000ABCDE, "R5 open");
      send(32'h000ABCDE, 0, 0, 8'hFE, 0, 0, 0, 32'h000ABCDE, "R5 closed");
      send(32'h000AB000, 1, 0, 8'h20, 1, 0, 1, 32'h000AB000, "R6 R10 smm data");
      send(32'h000AB000, 1, 1, 8'h20, 1, 1, 0, 32'h000AB000, "R6 R10 smm code");
      send(32'h0E0A0040, 0, 0, 8'h21, 1, 0, 1, 32'h000A0040, "R6 alias data");
      send(32'h4E0A0040, 0, 1, 8'h21, 1, 1, 0, 32'h000A0040, "R6 alias code");
      send(32'h000AB000, 0, 0, 8'h20, 0, 0, 0, 32'h000AB000, "R7 split closed");
      send(32'h0E0A0000, 0, 1, 8'h20, 0, 0, 0, 32'h0E0A0000, "R7 alias closed");
      send(32'h00100000, 1, 0, 8'h21, 0, 0, 0, 32'h00100000, "R9 far miss");
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule